// File: doc/BRIEF.md
# Prescaled Real-Time Counter with Dual Alarm

This block keeps time for a chip from a slow 32.768 kHz reference clock, `rtcClk`. A 16-bit prescaler divides the reference down to a slow tick. Every tick advances a 32-bit time counter and raises a periodic flag. Two compare registers raise alarm flags when the counter reaches their values. Each flag has its own enable. The enabled flags drive an interrupt line, and the enabled alarm flags also drive a wake-up line for the power controller.

Software reaches the block through a flat register bus made of an address, write data, a write strobe and combinational read data. All state is held in the bus clock domain. The reference clock enters through a three-stage synchronizer with an edge detector, which turns each rising edge into a one-cycle enable. Because the counter never changes in another domain, a counter read can never return a value that is partly updated. The bus clock must run at least four times faster than `rtcClk`.

Register map (byte offsets): time counter 0x00, alarm 0 at 0x04, status/enable at 0x08, prescaler 0x0C, power-control word 0x14, alarm 1 at 0x18, clock select 0x1C, scratch 0x40.

Top module: `rtc_alarm_timer`

## Requirements
- R1: After reset, every register reads 0, and `irq` and `wake` are low.
- R2: The prescaler and the counter advance only while the clock-select register (0x1C) holds 0x03. With any other value they hold.
- R3: A tick occurs once every 2·(P+1) rising edges of `rtcClk`, where P is the 16-bit prescaler value at 0x0C. Writing 0x0C restarts the prescaler at the start of a period, and bits above bit 15 read back as 0.
- R4: The counter at 0x00 increases by one on every tick and wraps from 0xFFFFFFFF to 0.
- R5: A write to 0x00 takes effect on the next rising edge of `rtcClk`, so a read before that edge returns the old value. If a tick falls on the same edge, the written value wins.
- R6: Every tick sets the periodic flag, which is status bit 1.
- R7: The alarm-0 flag (status bit 0) is set when the counter takes a value equal to the register at 0x04. The alarm-1 flag (status bit 4) is set in the same way from the register at 0x18. Both alarm registers read back as written.
- R8: Writing 1 to status bit 0, 1 or 4 clears that flag, and writing 0 leaves it unchanged. The enable bits 2 (alarm 0), 3 (periodic) and 6 (alarm 1) are written plainly and read back. Status bit 5 always reads 0.
- R9: `irq` is high exactly when at least one flag is set together with its enable.
- R10: `wake` is high exactly when an alarm flag is set together with its enable. The periodic flag never drives `wake`.
- R11: The scratch word (0x40) and the power-control word (0x14) hold whatever was last written and affect nothing else. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rtcClk | input | 1 | 32.768 kHz reference, asynchronous to clk |
| busAddr | input | 8 | Register byte address |
| busWdata | input | 32 | Write data |
| busWe | input | 1 | Write strobe, one write per clk cycle |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| irq | output | 1 | Any flag together with its enable |
| wake | output | 1 | Any alarm flag together with its enable |

## Verification
The bench counts reference edges one at a time, so it detects a prescaler that ticks one edge early or late, or that fails to restart when its value is rewritten. A counter write is placed on the same edge as a tick: a design that lets the increment win would show one more than the written value. The bench writes a mix of ones and zeros to the status word, which catches flags cleared by a 0, flags left set by a 1, and enables that are disturbed along the way. Finally, the bench raises the periodic flag with its enable set while no alarm is pending, which shows a design that wrongly lets that flag drive the wake-up line.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int NUM_ALM = 2;

  localparam logic [7:0] OFF_COUNT   = 8'h00;
  localparam logic [7:0] OFF_ALARM0  = 8'h04;
  localparam logic [7:0] OFF_STATUS  = 8'h08;
  localparam logic [7:0] OFF_DIV     = 8'h0C;
  localparam logic [7:0] OFF_PWRCTL  = 8'h14;
  localparam logic [7:0] OFF_ALARM1  = 8'h18;
  localparam logic [7:0] OFF_CLKSEL  = 8'h1C;
  localparam logic [7:0] OFF_SCRATCH = 8'h40;

  localparam logic [7:0] CLK_SEL_RTC = 8'h03;

  localparam int ST_HZ  = 1;
  localparam int ST_HZE = 3;

  // status positions of alarm flag / enable, indexed by alarm number
  function automatic int almFlagPos(input int idx);
    return (idx == 0) ? 0 : 4;
  endfunction

  function automatic int almEnPos(input int idx);
    return (idx == 0) ? 2 : 6;
  endfunction

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_COUNT,
    SEL_ALARM0,
    SEL_STATUS,
    SEL_DIV,
    SEL_PWRCTL,
    SEL_ALARM1,
    SEL_CLKSEL,
    SEL_SCRATCH
  } regSel_t;

  typedef struct packed {
    logic               rtcEdge;
    logic               tick;
    logic               wrCount;
    logic [NUM_ALM-1:0] wrAlarm;
    logic               wrStatus;
    logic               wrDiv;
    logic               wrPwrCtl;
    logic               wrClkSel;
    logic               wrScratch;
  } rtcStrobes_t;

endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rtcClk,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DIV_W-1:0]  divValue,
  input  logic              clkRun,
  output rtcStrobes_t       strb,
  output regSel_t           regSel
);

  localparam int SYNC_STAGES = 3;

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   rtcEdge;
  logic [DIV_W-1:0]       divCnt;
  logic                   divPhase;
  logic                   divWrap;

  // reference clock synchronizer and rising-edge detect
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], rtcClk};
  end

  assign rtcEdge = syncChain[SYNC_STAGES-2] & ~syncChain[SYNC_STAGES-1];

  // toggle-style prescaler: phase flips every divValue+1 edges
  assign divWrap = (divCnt >= divValue);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt   <= '0;
      divPhase <= 1'b0;
    end else if (strb.wrDiv) begin
      divCnt   <= '0;
      divPhase <= 1'b0;
    end else if (rtcEdge && clkRun) begin
      if (divWrap) begin
        divCnt   <= '0;
        divPhase <= ~divPhase;
      end else begin
        divCnt <= divCnt + DIV_W'(1);
      end
    end
  end

  // address decode
  always_comb begin
    regSel = SEL_NONE;
    case (busAddr)
      ADDR_W'(OFF_COUNT):   regSel = SEL_COUNT;
      ADDR_W'(OFF_ALARM0):  regSel = SEL_ALARM0;
      ADDR_W'(OFF_STATUS):  regSel = SEL_STATUS;
      ADDR_W'(OFF_DIV):     regSel = SEL_DIV;
      ADDR_W'(OFF_PWRCTL):  regSel = SEL_PWRCTL;
      ADDR_W'(OFF_ALARM1):  regSel = SEL_ALARM1;
      ADDR_W'(OFF_CLKSEL):  regSel = SEL_CLKSEL;
      ADDR_W'(OFF_SCRATCH): regSel = SEL_SCRATCH;
      default:              regSel = SEL_NONE;
    endcase
  end

  always_comb begin
    strb            = '0;
    strb.rtcEdge    = rtcEdge;
    strb.tick       = rtcEdge && clkRun && divWrap && divPhase;
    strb.wrCount    = busWe && (regSel == SEL_COUNT);
    strb.wrAlarm[0] = busWe && (regSel == SEL_ALARM0);
    strb.wrAlarm[1] = busWe && (regSel == SEL_ALARM1);
    strb.wrStatus   = busWe && (regSel == SEL_STATUS);
    strb.wrDiv      = busWe && (regSel == SEL_DIV);
    strb.wrPwrCtl   = busWe && (regSel == SEL_PWRCTL);
    strb.wrClkSel   = busWe && (regSel == SEL_CLKSEL);
    strb.wrScratch  = busWe && (regSel == SEL_SCRATCH);
  end

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rtcEdge |=> !rtcEdge); // R3

  AST_DIVCNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    divCnt <= divValue); // R3

endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DIV_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  rtcStrobes_t       strb,
  input  regSel_t           regSel,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [DIV_W-1:0]  divValue,
  output logic              clkRun,
  output logic              irq,
  output logic              wake
);

  localparam int SEL_W = 8;

  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   cntNext;
  logic               cntUpd;
  logic               loadPend;
  logic [CNT_W-1:0]   loadVal;
  logic               loadNow;
  logic [CNT_W-1:0]   alarmReg [NUM_ALM];
  logic [NUM_ALM-1:0] almFlag;
  logic [NUM_ALM-1:0] almEn;
  logic               hzFlag;
  logic               hzEn;
  logic [DIV_W-1:0]   divReg;
  logic [SEL_W-1:0]   clkSelReg;
  logic [DATA_W-1:0]  pwrCtlReg;
  logic [DATA_W-1:0]  scratchReg;
  logic [DATA_W-1:0]  statusWord;

  assign loadNow = strb.rtcEdge && loadPend;
  assign cntUpd  = loadNow || strb.tick;
  assign cntNext = loadNow ? loadVal : cnt + CNT_W'(1);

  // time counter with deferred load
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      loadPend <= 1'b0;
      loadVal  <= '0;
    end else begin
      if (cntUpd)   cnt <= cntNext;
      if (loadNow)  loadPend <= 1'b0;
      if (strb.wrCount) begin
        loadPend <= 1'b1;
        loadVal  <= busWdata[CNT_W-1:0];
      end
    end
  end

  // periodic flag and enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hzFlag <= 1'b0;
      hzEn   <= 1'b0;
    end else begin
      if (strb.tick)
        hzFlag <= 1'b1;
      else if (strb.wrStatus && busWdata[ST_HZ])
        hzFlag <= 1'b0;
      if (strb.wrStatus) hzEn <= busWdata[ST_HZE];
    end
  end

  // alarm compare units
  for (genvar g = 0; g < NUM_ALM; g++) begin : g_alm
    localparam int FLAG_POS = almFlagPos(g);
    localparam int EN_POS   = almEnPos(g);
    logic hit;

    assign hit = cntUpd && (cntNext == alarmReg[g]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        alarmReg[g] <= '0;
        almFlag[g]  <= 1'b0;
        almEn[g]    <= 1'b0;
      end else begin
        if (strb.wrAlarm[g]) alarmReg[g] <= busWdata[CNT_W-1:0];
        if (hit)
          almFlag[g] <= 1'b1;
        else if (strb.wrStatus && busWdata[FLAG_POS])
          almFlag[g] <= 1'b0;
        if (strb.wrStatus) almEn[g] <= busWdata[EN_POS];
      end
    end
  end

  // plain configuration and retained words
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg     <= '0;
      clkSelReg  <= '0;
      pwrCtlReg  <= '0;
      scratchReg <= '0;
    end else begin
      if (strb.wrDiv)     divReg     <= busWdata[DIV_W-1:0];
      if (strb.wrClkSel)  clkSelReg  <= busWdata[SEL_W-1:0];
      if (strb.wrPwrCtl)  pwrCtlReg  <= busWdata;
      if (strb.wrScratch) scratchReg <= busWdata;
    end
  end

  assign divValue = divReg;
  assign clkRun   = (clkSelReg == CLK_SEL_RTC);

  always_comb begin
    statusWord         = '0;
    statusWord[ST_HZ]  = hzFlag;
    statusWord[ST_HZE] = hzEn;
    for (int i = 0; i < NUM_ALM; i++) begin
      statusWord[almFlagPos(i)] = almFlag[i];
      statusWord[almEnPos(i)]   = almEn[i];
    end
  end

  always_comb begin
    case (regSel)
      SEL_COUNT:   busRdata = DATA_W'(cnt);
      SEL_ALARM0:  busRdata = DATA_W'(alarmReg[0]);
      SEL_ALARM1:  busRdata = DATA_W'(alarmReg[1]);
      SEL_STATUS:  busRdata = statusWord;
      SEL_DIV:     busRdata = DATA_W'(divReg);
      SEL_PWRCTL:  busRdata = pwrCtlReg;
      SEL_CLKSEL:  busRdata = DATA_W'(clkSelReg);
      SEL_SCRATCH: busRdata = scratchReg;
      default:     busRdata = '0;
    endcase
  end

  assign wake = |(almFlag & almEn);
  assign irq  = (hzFlag & hzEn) | wake;

  AST_HALT_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !clkRun |-> !strb.tick); // R2

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && !(strb.rtcEdge && loadPend)) |=> cnt == $past(cnt) + CNT_W'(1)); // R4

  AST_LOAD_APPLY: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rtcEdge && loadPend) |=> cnt == $past(loadVal)); // R5

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rtcEdge |=> $stable(cnt)); // R5

  AST_HZ_SET: assert property (@(posedge clk) disable iff (!rstN)
    strb.tick |=> hzFlag); // R6

endmodule

// File: rtl/rtc_alarm_timer.sv
module rtc_alarm_timer
  import rtc_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DIV_W  = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rtcClk,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWe,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq,
  output logic              wake
);

  rtcStrobes_t      strb;
  regSel_t          regSel;
  logic [DIV_W-1:0] divValue;
  logic             clkRun;

  rtc_ctrl #(
    .DIV_W (DIV_W),
    .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .rtcClk  (rtcClk),
    .busAddr (busAddr),
    .busWe   (busWe),
    .divValue(divValue),
    .clkRun  (clkRun),
    .strb    (strb),
    .regSel  (regSel)
  );

  rtc_datapath #(
    .CNT_W (CNT_W),
    .DIV_W (DIV_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .regSel  (regSel),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .divValue(divValue),
    .clkRun  (clkRun),
    .irq     (irq),
    .wake    (wake)
  );

  AST_WAKE_IMPLIES_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    wake |-> irq); // R10

endmodule

// File: tb/rtc_alarm_timer_bench.sv
module rtc_alarm_timer_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rtcClk = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busWe = 1'b0;
  logic [31:0] busRdata;
  logic        irq;
  logic        wake;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rtc_alarm_timer u_rtc_alarm_timer (
    .clk     (clk),
    .rstN    (rstN),
    .rtcClk  (rtcClk),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .busWe   (busWe),
    .busRdata(busRdata),
    .irq     (irq),
    .wake    (wake)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic rtcPulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rtcClk = 1'b1;
      repeat (6) @(negedge clk);
      rtcClk = 1'b0;
      repeat (6) @(negedge clk);
    end
  endtask

  task automatic expectReg(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    busRead(a, v);
    check(tag, v, exp);
  endtask

  task automatic testReset();
    expectReg("R1 counter", 8'h00, 0);
    expectReg("R1 alarm0", 8'h04, 0);
    expectReg("R1 status", 8'h08, 0);
    expectReg("R1 div", 8'h0C, 0);
    expectReg("R1 clksel", 8'h1C, 0);
    expectReg("R1 scratch", 8'h40, 0);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 wake", {31'b0, wake}, 0);
  endtask

  task automatic testHalt();
    busWrite(8'h0C, 0);
    rtcPulse(4);
    expectReg("R2 halted counter sel=0", 8'h00, 0);
    busWrite(8'h1C, 2);
    rtcPulse(4);
    expectReg("R2 halted counter sel=2", 8'h00, 0);
    expectReg("R2 no periodic flag", 8'h08, 0);
  endtask

  task automatic testDivider();
    busWrite(8'h1C, 3);
    busWrite(8'h0C, 1);
    rtcPulse(3);
    expectReg("R3 no tick before 4 edges", 8'h00, 0);
    expectReg("R6 no flag before tick", 8'h08, 0);
    rtcPulse(1);
    expectReg("R4 count after first tick", 8'h00, 1);
    expectReg("R6 periodic flag set", 8'h08, 32'h02);
    busWrite(8'h0C, 0);
    rtcPulse(1);
    expectReg("R3 div0 restarted, one edge", 8'h00, 1);
    rtcPulse(1);
    expectReg("R3 div0 tick on second edge", 8'h00, 2);
  endtask

  task automatic testFlags();
    check("R9 flag without enable", {31'b0, irq}, 0);
    busWrite(8'h08, 32'h08);
    expectReg("R8 zero leaves flag, enable set", 8'h08, 32'h0A);
    check("R9 irq periodic enabled", {31'b0, irq}, 1);
    check("R10 wake ignores periodic", {31'b0, wake}, 0);
    busWrite(8'h08, 32'h0A);
    expectReg("R8 one clears periodic", 8'h08, 32'h08);
    check("R9 irq low after clear", {31'b0, irq}, 0);
  endtask

  task automatic testAlarms();
    busWrite(8'h04, 4);
    busWrite(8'h18, 5);
    expectReg("R7 alarm0 readback", 8'h04, 4);
    expectReg("R7 alarm1 readback", 8'h18, 5);
    busWrite(8'h08, 32'h46);
    expectReg("R8 enables only", 8'h08, 32'h44);
    rtcPulse(2);
    expectReg("R7 no match at 3", 8'h08, 32'h46);
    check("R9 periodic disabled no irq", {31'b0, irq}, 0);
    rtcPulse(2);
    expectReg("R7 alarm0 hit", 8'h08, 32'h47);
    check("R10 wake alarm0", {31'b0, wake}, 1);
    check("R9 irq alarm0", {31'b0, irq}, 1);
    busWrite(8'h08, 32'h47);
    expectReg("R8 clear alarm0 and periodic", 8'h08, 32'h44);
    check("R10 wake low", {31'b0, wake}, 0);
    rtcPulse(2);
    expectReg("R7 alarm1 hit", 8'h08, 32'h56);
    check("R10 wake alarm1", {31'b0, wake}, 1);
    busWrite(8'h08, 32'h54);
    expectReg("R8 clear alarm1 only", 8'h08, 32'h46);
    check("R10 wake low again", {31'b0, wake}, 0);
  endtask

  task automatic testLoad();
    busWrite(8'h00, 32'h1234);
    expectReg("R5 old value before edge", 8'h00, 5);
    rtcPulse(1);
    expectReg("R5 loaded on edge", 8'h00, 32'h1234);
    rtcPulse(1);
    expectReg("R4 counts from loaded", 8'h00, 32'h1235);
    rtcPulse(1);
    busWrite(8'h00, 32'h50);
    rtcPulse(1);
    expectReg("R5 load wins over tick", 8'h00, 32'h50);
  endtask

  task automatic testWrap();
    busWrite(8'h08, 32'h57);
    expectReg("R8 flags cleared", 8'h08, 32'h44);
    busWrite(8'h04, 0);
    busWrite(8'h00, 32'hFFFF_FFFF);
    rtcPulse(1);
    expectReg("R5 max loaded", 8'h00, 32'hFFFF_FFFF);
    rtcPulse(1);
    expectReg("R4 wrap to zero", 8'h00, 0);
    expectReg("R7 alarm0 at zero", 8'h08, 32'h47);
    check("R10 wake on wrap alarm", {31'b0, wake}, 1);
  endtask

  task automatic testMisc();
    busWrite(8'h40, 32'hCAFE_0001);
    busWrite(8'h14, 32'h0000_005A);
    expectReg("R11 scratch retained", 8'h40, 32'hCAFE_0001);
    expectReg("R11 power word retained", 8'h14, 32'h5A);
    expectReg("R11 counter untouched", 8'h00, 0);
    expectReg("R11 unmapped reads zero", 8'h10, 0);
    expectReg("R2 clksel readback", 8'h1C, 3);
    busWrite(8'h0C, 32'h0001_FFFF);
    expectReg("R3 div 16 bits", 8'h0C, 32'h0000_FFFF);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testHalt();
    testDivider();
    testFlags();
    testAlarms();
    testLoad();
    testWrap();
    testMisc();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule